// File: doc/BRIEF.md
# ASCII Hex Record Loader

This block takes a text stream, one character per valid/ready handshake, and turns it into byte writes on a simple memory port (address, data, write enable). The text is a series of records. Each record has a header line and, when its count is not zero, a data line. The header gives a four-digit hex start address, a space, and a hex byte count that ends with a space. Anything after that space up to the line feed is free comment. The data line holds the bytes as hex pairs, and every pair is followed by one space. Text after the final pair and its space is comment.

Hex characters are decoded by offset into the range from '0' to 'F'. The punctuation codes between the digits and the letters are rejected. Each byte is written to the next address in turn, starting at the record's start address. A record-done strobe marks the write of its final byte. Malformed text raises a sticky error flag. The parser then throws away the rest of that line and starts again at a header.

Top module: `hexld_top`

## Requirements
- R1: While reset is high and in the first cycle after it, s_ready is 1, and mem_we, rec_done and err are 0.
- R2: A header is four hex digits (the address, most significant digit first), then one space (0x20), then a count of one or two hex digits ended by a space. Every character after that space up to the line feed (0x0A) is ignored.
- R3: A data byte is two hex digits, the high nibble first. Each data byte is followed by exactly one space. The byte value is written as mem_data.
- R4: The bytes of a record go to consecutive addresses. The first is the start address, and each later byte goes one address higher, wrapping modulo 2^16.
- R5: After the space that follows the last byte, the rest of the line is ignored up to the line feed. The next line is parsed as a header.
- R6: rec_done is high in the same cycle as the write of a record's last byte, and in no other cycle. A count of zero produces no write and no rec_done, and the next line is a header.
- R7: Each byte is written in a single cycle with mem_we high. That cycle is the cycle after the handshake that delivers the byte's low digit. s_ready is low in that cycle.
- R8: Valid digits are 0x30–0x39, with values 0–9, and 0x41–0x46, with values 10–15. Codes 0x3A–0x40 and lowercase letters are invalid digits.
- R9: err goes high and stays high until reset in any of these cases: an invalid digit where a digit is expected, a missing space, a third count digit, or a line feed before the line is complete. The parser then discards input up to the line feed, makes no write, and expects a header next.
- R10: A carriage return (0x0D) is ignored in every state. A line feed at the very start of a header line is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_data | input | 8 | Incoming ASCII character |
| s_valid | input | 1 | Character is valid |
| s_ready | output | 1 | Block accepts a character this cycle |
| mem_addr | output | 16 | Write address |
| mem_data | output | 8 | Write data byte |
| mem_we | output | 1 | Write enable, one cycle per byte |
| rec_done | output | 1 | Strobe on the final byte of a record |
| err | output | 1 | Sticky malformed-input flag |

## Verification
A wrong parser state shows up at the ports within one line of text. It appears as a write that should not happen, a missing write, an error flag raised on clean text, or a later record landing at the wrong address. A wrong address or byte accumulator shows in the very next write's address or data. A wrong remaining-count register shows as rec_done on the wrong write, or as the following header being parsed as data. A drop state that fails to clear is caught because a good record is sent after each malformed line and must still be written.

// File: rtl/hexld_pkg.sv
package hexld_pkg;

    localparam logic [7:0] CH_LF   = 8'h0A;
    localparam logic [7:0] CH_CR   = 8'h0D;
    localparam logic [7:0] CH_SP   = 8'h20;
    localparam logic [7:0] CH_LOW  = 8'h30;
    localparam logic [7:0] CH_HIGH = 8'h46;
    localparam logic [7:0] CH_NINE = 8'h39;
    localparam logic [7:0] CH_A    = 8'h41;

    typedef enum logic [3:0] {
        ST_ADDR,
        ST_ASEP,
        ST_CNT,
        ST_HSKIP,
        ST_DHI,
        ST_DLO,
        ST_DSEP,
        ST_DSKIP,
        ST_DROP
    } hexld_state_e;

    typedef struct packed {
        logic       is_digit;
        logic [3:0] val;
        logic       is_lf;
        logic       is_cr;
        logic       is_sp;
    } char_class_t;

    function automatic char_class_t classify(input logic [7:0] c);
        char_class_t r;
        logic in_span;
        logic in_gap;
        in_span    = (c >= CH_LOW) && (c <= CH_HIGH);
        in_gap     = (c > CH_NINE) && (c < CH_A);
        r.is_digit = in_span && !in_gap;
        r.val      = (c <= CH_NINE) ? c[3:0] : 4'(c[3:0] + 4'd9);
        r.is_lf    = (c == CH_LF);
        r.is_cr    = (c == CH_CR);
        r.is_sp    = (c == CH_SP);
        return r;
    endfunction

endpackage

// File: rtl/hexld_char_class.sv
module hexld_char_class
    import hexld_pkg::*;
(
    input  logic [7:0]  ch,
    output char_class_t cls
);
    assign cls = classify(ch);
endmodule

// File: rtl/hexld_fsm.sv
module hexld_fsm
    import hexld_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int CNT_DIGITS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  char_class_t       cls,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_data,
    output logic              mem_we,
    output logic              rec_done,
    output logic              err
);
    localparam int ADDR_DIGITS = ADDR_W / 4;
    localparam int CNT_W       = 4 * CNT_DIGITS;
    localparam int MAXD        = (ADDR_DIGITS > CNT_DIGITS) ? ADDR_DIGITS : CNT_DIGITS;
    localparam int DC_W        = $clog2(MAXD + 1);

    hexld_state_e      state, st_n;
    logic [DC_W-1:0]   dcnt;
    logic [ADDR_W-1:0] addr_acc;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  remain;
    logic [3:0]        hi_nib;

    logic shift_addr, shift_cnt, clr_cnt, load_ptr, load_hi, do_write, bad, clr_dc;

    always_comb begin
        st_n       = state;
        shift_addr = 1'b0;
        shift_cnt  = 1'b0;
        clr_cnt    = 1'b0;
        load_ptr   = 1'b0;
        load_hi    = 1'b0;
        do_write   = 1'b0;
        bad        = 1'b0;
        clr_dc     = 1'b0;
        if (take && !cls.is_cr) begin
            unique case (state)
                ST_ADDR: begin
                    if (cls.is_digit) begin
                        shift_addr = 1'b1;
                        if (dcnt == DC_W'(ADDR_DIGITS - 1)) begin
                            st_n   = ST_ASEP;
                            clr_dc = 1'b1;
                        end
                    end else if (!(cls.is_lf && dcnt == '0)) begin
                        bad = 1'b1;
                    end
                end
                ST_ASEP: begin
                    if (cls.is_sp) begin
                        st_n    = ST_CNT;
                        clr_cnt = 1'b1;
                        clr_dc  = 1'b1;
                    end else bad = 1'b1;
                end
                ST_CNT: begin
                    if (cls.is_digit && dcnt < DC_W'(CNT_DIGITS)) shift_cnt = 1'b1;
                    else if (cls.is_sp && dcnt != '0) begin
                        st_n     = ST_HSKIP;
                        load_ptr = 1'b1;
                    end else bad = 1'b1;
                end
                ST_HSKIP: begin
                    if (cls.is_lf) begin
                        st_n   = (remain == '0) ? ST_ADDR : ST_DHI;
                        clr_dc = 1'b1;
                    end
                end
                ST_DHI: begin
                    if (cls.is_digit) begin
                        load_hi = 1'b1;
                        st_n    = ST_DLO;
                    end else bad = 1'b1;
                end
                ST_DLO: begin
                    if (cls.is_digit) begin
                        do_write = 1'b1;
                        st_n     = ST_DSEP;
                    end else bad = 1'b1;
                end
                ST_DSEP: begin
                    if (cls.is_sp) st_n = (remain == '0) ? ST_DSKIP : ST_DHI;
                    else bad = 1'b1;
                end
                ST_DSKIP, ST_DROP: begin
                    if (cls.is_lf) begin
                        st_n   = ST_ADDR;
                        clr_dc = 1'b1;
                    end
                end
                default: st_n = ST_ADDR;
            endcase
            if (bad) begin
                st_n   = cls.is_lf ? ST_ADDR : ST_DROP;
                clr_dc = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_ADDR;
            dcnt     <= '0;
            addr_acc <= '0;
            cur_addr <= '0;
            remain   <= '0;
            hi_nib   <= '0;
            mem_we   <= 1'b0;
            mem_addr <= '0;
            mem_data <= '0;
            rec_done <= 1'b0;
            err      <= 1'b0;
        end else begin
            state    <= st_n;
            mem_we   <= do_write;
            rec_done <= do_write && (remain == CNT_W'(1));
            if (bad) err <= 1'b1;
            if (clr_dc) dcnt <= '0;
            else if (shift_addr || shift_cnt) dcnt <= dcnt + 1'b1;
            if (shift_addr) addr_acc <= {addr_acc[ADDR_W-5:0], cls.val};
            if (clr_cnt) remain <= '0;
            else if (shift_cnt) remain <= {remain[CNT_W-5:0], cls.val};
            else if (do_write) remain <= remain - 1'b1;
            if (load_ptr) cur_addr <= addr_acc;
            else if (do_write) cur_addr <= cur_addr + 1'b1;
            if (load_hi) hi_nib <= cls.val;
            if (do_write) begin
                mem_addr <= cur_addr;
                mem_data <= {hi_nib, cls.val};
            end
        end
    end
endmodule

// File: rtl/hexld_top.sv
module hexld_top
    import hexld_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int CNT_DIGITS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        s_data,
    input  logic              s_valid,
    output logic              s_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_data,
    output logic              mem_we,
    output logic              rec_done,
    output logic              err
);
    char_class_t cls;
    logic        take;

    assign s_ready = !mem_we;
    assign take    = s_valid && s_ready;

    hexld_char_class u_cls (
        .ch  (s_data),
        .cls (cls)
    );

    hexld_fsm #(
        .ADDR_W     (ADDR_W),
        .CNT_DIGITS (CNT_DIGITS)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .cls      (cls),
        .mem_addr (mem_addr),
        .mem_data (mem_data),
        .mem_we   (mem_we),
        .rec_done (rec_done),
        .err      (err)
    );
endmodule

// File: rtl/hexld_chk.sv
module hexld_chk (
    input logic clk,
    input logic rst,
    input logic s_valid,
    input logic s_ready,
    input logic mem_we,
    input logic rec_done,
    input logic err
);
    p_we_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    p_ready_low_r7: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !s_ready);

    p_we_needs_accept_r7: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(s_valid && s_ready));

    p_done_with_we_r6: assert property (@(posedge clk) disable iff (rst)
        rec_done |-> mem_we);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        err |=> err);
endmodule

bind hexld_top hexld_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .s_valid  (s_valid),
    .s_ready  (s_ready),
    .mem_we   (mem_we),
    .rec_done (rec_done),
    .err      (err)
);

// File: tb/hexld_top_tb_top.sv
module hexld_top_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  s_data;
    logic        s_valid;
    logic        s_ready;
    logic [15:0] mem_addr;
    logic [7:0]  mem_data;
    logic        mem_we;
    logic        rec_done;
    logic        err;

    always #4 clk = ~clk;

    hexld_top dut_i (
        .clk(clk), .rst(rst), .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_we(mem_we),
        .rec_done(rec_done), .err(err)
    );

    typedef struct packed {
        logic        done;
        logic [15:0] a;
        logic [7:0]  d;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    int   cyc    = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic put_char(input byte c);
        s_data  = c;
        s_valid = 1'b1;
        while (!s_ready) @(negedge clk);
        @(negedge clk);
        s_valid = 1'b0;
    endtask

    task automatic put_str(input string s);
        for (int i = 0; i < s.len(); i++) put_char(s[i]);
    endtask

    task automatic expect_wr(input logic [15:0] a, input logic [7:0] d, input logic done);
        exp_t e;
        e.a = a; e.d = d; e.done = done;
        q.push_back(e);
    endtask

    task automatic drain(input string req);
        repeat (4) @(negedge clk);
        check(q.size() == 0, req, "pending writes", q.size(), 0);
        q.delete();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        s_valid = 1'b0;
        s_data = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    function automatic byte hexch(input int v);
        return (v < 10) ? byte'(8'h30 + v) : byte'(8'h41 + v - 10);
    endfunction

    // Monitor: pop and compare every write
    always @(negedge clk) begin
        if (!rst && mem_we) begin
            check(!s_ready, "R7", "s_ready during write", s_ready, 0);
            if (q.size() == 0) begin
                check(1'b0, "R9", "unexpected write addr", mem_addr, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(mem_addr == e.a, "R4", "write address", mem_addr, e.a);
                check(mem_data == e.d, "R3", "write data", mem_data, e.d);
                check(rec_done == e.done, "R6", "rec_done", rec_done, e.done);
            end
        end else if (!rst && rec_done) begin
            check(1'b0, "R6", "rec_done without write", rec_done, 0);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        s_valid = 1'b0;
        s_data = 8'h00;
        @(negedge clk);
        check(s_ready == 1'b1, "R1", "s_ready in reset", s_ready, 1);
        check(mem_we == 1'b0 && rec_done == 1'b0, "R1", "we/done in reset", mem_we, 0);
        check(err == 1'b0, "R1", "err in reset", err, 0);
        do_reset();
        check(s_ready == 1'b1 && err == 1'b0, "R1", "after reset", s_ready, 1);

        // R2 R3 R4 R5: record with header comment and trailing comment, CR (R10)
        put_str("\n\r\n");
        put_str("12AC 7 seven bytes here\r\n");
        expect_wr(16'h12AC, 8'hAE, 0); expect_wr(16'h12AD, 8'h03, 0);
        expect_wr(16'h12AE, 8'hB6, 0); expect_wr(16'h12AF, 8'h91, 0);
        expect_wr(16'h12B0, 8'hC7, 0); expect_wr(16'h12B1, 8'h00, 0);
        expect_wr(16'h12B2, 8'h0C, 1);
        put_str("AE 03 B6\r 91 C7 00 0C tail 12 34\r\n");
        drain("R5");
        check(err == 1'b0, "R10", "err after clean record", err, 0);

        // R4 address wrap, R8 boundary digits 9 A F 0
        put_str("FFFF 2 \n");
        expect_wr(16'hFFFF, 8'h9A, 0); expect_wr(16'h0000, 8'hF0, 1);
        put_str("9A F0 \n");
        drain("R4");

        // R6 zero count: next line is a header
        put_str("0100 0 nothing\n");
        expect_wr(16'h0200, 8'h5A, 1);
        put_str("0200 1 \n5A \n");
        drain("R6");

        // R2 two-digit count of 0x10 bytes
        put_str("0300 10 sixteen\n");
        for (int i = 0; i < 16; i++) begin
            expect_wr(16'h0300 + 16'(i), 8'(i * 17), (i == 15));
            put_char(hexch(i)); put_char(hexch(i)); put_char(8'h20);
        end
        put_char(8'h0A);
        drain("R2");
        check(err == 1'b0, "R2", "err after clean stream", err, 0);

        // R9 lowercase digit: error, line dropped, next record still written
        put_str("0400 1 \nab \n");
        repeat (2) @(negedge clk);
        check(err == 1'b1, "R8", "err on lowercase", err, 1);
        expect_wr(16'h0500, 8'h3C, 1);
        put_str("0500 1 \n3C \n");
        drain("R9");
        check(err == 1'b1, "R9", "err sticky", err, 1);

        // R8 ':' inside address
        do_reset();
        put_str("04:0 1 \n");
        check(err == 1'b1, "R8", "err on colon", err, 1);
        expect_wr(16'h0600, 8'h77, 1);
        put_str("0600 1 \n77 \n");
        drain("R8");

        // R9 missing space between bytes
        do_reset();
        expect_wr(16'h0700, 8'h11, 0);
        put_str("0700 2 \n1122 \n");
        drain("R9");
        check(err == 1'b1, "R9", "err on missing space", err, 1);
        expect_wr(16'h0710, 8'hAB, 1);
        put_str("0710 1 \nAB \n");
        drain("R9");

        // R9 third count digit: discarded, no writes
        do_reset();
        put_str("0800 123 \n44 \n");
        drain("R9");
        check(err == 1'b1, "R9", "err on long count", err, 1);

        // R9 premature line feed in count field
        do_reset();
        put_str("0900 2\n");
        check(err == 1'b1, "R9", "err on early LF", err, 1);
        expect_wr(16'h0A00, 8'h01, 1);
        put_str("0A00 1 \n01 \n");
        drain("R9");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule